// File: doc/BRIEF.md
# Generation-Configurable Processor Flags Register

This block holds the status and control flags of a processor whose behaviour follows one of five processor generations. The generations, selected by the `GEN` parameter, are: 0 for the original 16-bit part, 1 for its 16-bit protected-mode successor, 2 for the first 32-bit part, 3 for the second 32-bit part, and 4 for the third and later 32-bit parts.

Each generation fixes three things:
- which flag bits software can write;
- which bits are tied to a constant;
- what image of the flags goes onto the stack when flags are saved.

Software can therefore tell the generations apart by writing bits and reading them back. The block also chooses which stack-pointer value a push of the stack pointer stores.

Arithmetic flag computation, instruction decoding and memory access are handled elsewhere. The surrounding core provides:
- a write with its enable;
- the real-mode indication;
- the current stack pointer.

It reads back the stored flags, the push image and the pushed stack-pointer value.

Top module: `gen_flags_reg`

## Requirements
- R1: A synchronous reset loads the stored flags with 0x00000002.
- R2: With `wr_en` high, `rd_data` shows the written value, after masking, from the next rising edge. With `wr_en` low, `rd_data` keeps its value.
- R3: In `rd_data`, bit 1 always reads 1. Bits 3, 5, 15 and 22 to 31 always read 0. On generations 0 and 1, bits 16 to 31 read 0.
- R4: Bit 18 (alignment check) reads 0 on generations 0, 1 and 2 whatever is written. On generations 3 and 4 it can be set and cleared.
- R5: Bit 21 (identification) and bits 19 and 20 (virtual interrupt and its pending bit) can be set and cleared only on generation 4. On every other generation they read 0.
- R6: The writable bits are set by generation:
  - bits 0, 2, 4 and 6 to 11 are writable on every generation;
  - bits 12 to 14 are writable from generation 1 on and read 0 on generation 0;
  - bits 16 and 17 are writable from generation 2 on.
- R7: On generation 0, `push_img` equals `rd_data` with bits 12 to 15 forced to 1, in any mode.
- R8: On generation 1, `push_img` equals `rd_data` with bits 12 to 15 forced to 0 while `real_mode` is high. While `real_mode` is low, it equals `rd_data`.
- R9: On generations 2 to 4, `push_img` equals `rd_data` in both modes. Bit 15 is therefore 0, and bits 12 to 14 hold the last values loaded into them.
- R10: `sp_push_val` is the stack pointer to store for a push of the stack pointer:
  - on generation 0 it is `sp_in` minus 2, modulo 2^SP_W (the value after the decrement);
  - on all other generations it is `sp_in` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write enable for the flags |
| wr_data | input | 32 | Value to write |
| real_mode | input | 1 | High while the core runs in real-address mode |
| sp_in | input | SP_W | Stack pointer before the push decrement |
| rd_data | output | 32 | Stored flags as read by software |
| push_img | output | 32 | Flags image to store on a flag push, interrupt or exception |
| sp_push_val | output | SP_W | Value stored by a push of the stack pointer |

## Verification
The bench builds five copies of the block, one for each `GEN` value from 0 to 4, with the default `SP_W` of 32. It drives all five with the same writes, mode changes and stack-pointer values. Each write pattern is therefore checked against every generation's mask and push rule in the same cycle.

A probe writes bits 18 and 21 as ones and then as zeros, which separates generations 2, 3 and 4 in the same way as a software probe would. A stack pointer of zero exercises the wrap of the generation-0 decrement.

// File: rtl/gen_flags_reg.sv
module gen_flags_reg #(
  parameter int GEN  = 4,
  parameter int SP_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [31:0]     wr_data,
  input  logic            real_mode,
  input  logic [SP_W-1:0] sp_in,
  output logic [31:0]     rd_data,
  output logic [31:0]     push_img,
  output logic [SP_W-1:0] sp_push_val
);

  localparam logic [31:0] BASE_WR = 32'h0000_0FD5;
  localparam logic [31:0] PRIV_WR = (GEN >= 1) ? 32'h0000_7000 : 32'h0;
  localparam logic [31:0] EXT_WR  = (GEN >= 2) ? 32'h0003_0000 : 32'h0;
  localparam logic [31:0] ALGN_WR = (GEN >= 3) ? 32'h0004_0000 : 32'h0;
  localparam logic [31:0] IDV_WR  = (GEN >= 4) ? 32'h0038_0000 : 32'h0;
  localparam logic [31:0] WR_MASK = BASE_WR | PRIV_WR | EXT_WR | ALGN_WR | IDV_WR;
  localparam logic [31:0] ONES    = 32'h0000_0002;
  localparam logic [31:0] NIBBLE  = 32'h0000_F000;

  logic [31:0] flags_q;

  always_ff @(posedge clk) begin
    if (rst)        flags_q <= ONES;
    else if (wr_en) flags_q <= (wr_data & WR_MASK) | ONES;
  end

  assign rd_data = flags_q;

  generate
    if (GEN == 0) begin : g_push_orig
      assign push_img    = flags_q | NIBBLE;
      assign sp_push_val = sp_in - SP_W'(2);
    end else if (GEN == 1) begin : g_push_prot16
      assign push_img    = real_mode ? (flags_q & ~NIBBLE) : flags_q;
      assign sp_push_val = sp_in;
    end else begin : g_push_32
      assign push_img    = flags_q;
      assign sp_push_val = sp_in;
    end
  endgenerate

endmodule

// File: rtl/gen_flags_chk.sv
module gen_flags_chk #(
  parameter int GEN  = 4,
  parameter int SP_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic            real_mode,
  input logic [SP_W-1:0] sp_in,
  input logic [31:0]     rd_data,
  input logic [31:0]     push_img,
  input logic [SP_W-1:0] sp_push_val
);

  assert_reset_val_R1: assert property (@(posedge clk) rst |=> rd_data == 32'h2);

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(rd_data));

  assert_fixed_bits_R3: assert property (@(posedge clk) disable iff (rst)
    rd_data[1] && !rd_data[3] && !rd_data[5] && !rd_data[15] && rd_data[31:22] == 10'h0);

  generate
    if (GEN < 2) begin : g_narrow
      assert_narrow_R3: assert property (@(posedge clk) disable iff (rst)
        rd_data[31:16] == 16'h0);
    end
    if (GEN < 3) begin : g_no_align
      assert_no_align_R4: assert property (@(posedge clk) disable iff (rst) !rd_data[18]);
    end
    if (GEN < 4) begin : g_no_id
      assert_no_id_R5: assert property (@(posedge clk) disable iff (rst)
        rd_data[21:19] == 3'b000);
    end
    if (GEN == 0) begin : g_orig
      assert_no_priv_R6: assert property (@(posedge clk) disable iff (rst)
        rd_data[14:12] == 3'b000);
      assert_push_ones_R7: assert property (@(posedge clk) disable iff (rst)
        push_img[15:12] == 4'hF && push_img[11:0] == rd_data[11:0]);
      assert_sp_after_R10: assert property (@(posedge clk) disable iff (rst)
        sp_push_val + SP_W'(2) == sp_in);
    end else begin : g_later
      assert_sp_before_R10: assert property (@(posedge clk) disable iff (rst)
        sp_push_val == sp_in);
    end
    if (GEN == 1) begin : g_prot16
      assert_push_real_R8: assert property (@(posedge clk) disable iff (rst)
        real_mode |-> push_img[15:12] == 4'h0);
      assert_push_prot_R8: assert property (@(posedge clk) disable iff (rst)
        !real_mode |-> push_img == rd_data);
    end
    if (GEN >= 2) begin : g_wide
      assert_push_equal_R9: assert property (@(posedge clk) disable iff (rst)
        push_img == rd_data);
    end
  endgenerate

endmodule

bind gen_flags_reg gen_flags_chk #(.GEN(GEN), .SP_W(SP_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .real_mode(real_mode), .sp_in(sp_in),
  .rd_data(rd_data), .push_img(push_img), .sp_push_val(sp_push_val)
);

// File: tb/tb_gen_flags_reg.sv
module tb_gen_flags_reg;
  localparam int NG = 5;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [31:0] wr_data;
  logic        real_mode;
  logic [31:0] sp_in;
  logic [31:0] rd_a   [NG];
  logic [31:0] push_a [NG];
  logic [31:0] sp_a   [NG];

  int checks = 0;
  int errors = 0;

  always #4ns clk = ~clk;

  for (genvar gi = 0; gi < NG; gi++) begin : g_gen
    gen_flags_reg #(.GEN(gi), .SP_W(32)) dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
      .real_mode(real_mode), .sp_in(sp_in), .rd_data(rd_a[gi]),
      .push_img(push_a[gi]), .sp_push_val(sp_a[gi])
    );
  end

  // Writable bits per generation, taken from R4, R5 and R6
  function automatic logic [31:0] wmask(int g);
    logic [31:0] m = 32'h0000_0FD5;
    if (g >= 1) m |= 32'h0000_7000;
    if (g >= 2) m |= 32'h0003_0000;
    if (g >= 3) m |= 32'h0004_0000;
    if (g >= 4) m |= 32'h0038_0000;
    return m;
  endfunction

  function automatic logic [31:0] exp_push(int g, logic [31:0] rd, logic rm);
    if (g == 0) return rd | 32'h0000_F000;
    if (g == 1 && rm) return rd & 32'hFFFF_0FFF;
    return rd;
  endfunction

  task automatic chk(string req, int g, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s gen %0d actual %08h expected %08h", req, g, act, exp);
    end
  endtask

  task automatic do_write(logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    for (int g = 0; g < NG; g++) chk("R1", g, rd_a[g], 32'h2);
  endtask

  task automatic t_patterns();
    logic [31:0] pats [4] = '{32'hFFFF_FFFF, 32'h0000_0000, 32'hA5A5_A5A5, 32'h5A5A_5A5A};
    foreach (pats[i]) begin
      do_write(pats[i]);
      for (int g = 0; g < NG; g++) begin
        chk("R6", g, rd_a[g], (pats[i] & wmask(g)) | 32'h2);
        chk("R3", g, rd_a[g] & 32'hFFC0_802A, 32'h2);
      end
    end
    wr_data = 32'hFFFF_FFFF;
    @(negedge clk); @(negedge clk);
    for (int g = 0; g < NG; g++) chk("R2", g, rd_a[g], (32'h5A5A_5A5A & wmask(g)) | 32'h2);
  endtask

  task automatic t_probe();
    do_write(32'h0024_0000);
    for (int g = 0; g < NG; g++) begin
      chk("R4", g, {31'h0, rd_a[g][18]}, (g >= 3) ? 32'h1 : 32'h0);
      chk("R5", g, {31'h0, rd_a[g][21]}, (g >= 4) ? 32'h1 : 32'h0);
    end
    do_write(32'h0018_0000);
    for (int g = 0; g < NG; g++) begin
      chk("R5", g, {29'h0, rd_a[g][21:19]}, (g >= 4) ? 32'h3 : 32'h0);
      chk("R4", g, {31'h0, rd_a[g][18]}, 32'h0);
    end
    do_write(32'h0000_0000);
    for (int g = 0; g < NG; g++) chk("R5", g, rd_a[g], 32'h2);
  endtask

  task automatic t_push();
    logic [31:0] vals [2] = '{32'h0000_7FFF, 32'h0000_5ED5};
    foreach (vals[i]) begin
      do_write(vals[i]);
      for (int m = 0; m < 2; m++) begin
        real_mode = (m == 0);
        #1ns;
        for (int g = 0; g < NG; g++)
          chk((g == 0) ? "R7" : (g == 1) ? "R8" : "R9", g, push_a[g],
              exp_push(g, (vals[i] & wmask(g)) | 32'h2, real_mode));
      end
    end
    real_mode = 1'b1;
  endtask

  task automatic t_sp();
    logic [31:0] sps [3] = '{32'h0000_0100, 32'h0000_0000, 32'h1234_5679};
    foreach (sps[i]) begin
      sp_in = sps[i];
      #1ns;
      for (int g = 0; g < NG; g++)
        chk("R10", g, sp_a[g], (g == 0) ? sps[i] - 32'd2 : sps[i]);
    end
  endtask

  initial begin
    #(8ns * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_data = '0; real_mode = 1'b1; sp_in = '0;
    t_reset();
    t_patterns();
    t_probe();
    t_push();
    t_sp();
    do_write(32'hFFFF_FFFF);
    t_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule